// File: doc/BRIEF.md
# Pin Bank with Level and Edge Event Detection

This block is a bank of general-purpose pins on a simple 32-bit register bus. Each pin can be an input or a driven output. Software controls the direction with an output-enable register, in which a 1 means input. Software sets the driven value through a data register or through atomic set and clear aliases, and reads the pin state through a synchronised data-in register.

Every pin has four separate event-select registers: low level, high level, rising edge and falling edge. Any mix of them may be enabled on one pin. A pin whose synchronised input meets an enabled condition sets its bit in a write-1-to-clear event status register. A level event keeps its bit set for as long as the level is held, so clearing that bit has no effect until the input moves away.

The bank raises one interrupt line from the status bits selected by an interrupt-enable mask. It raises one wake-up line from the status bits selected by a separate wake-up mask. Both masks have set and clear aliases. A control bit can suspend event capture. A revision word identifies the version of the bank.

Top module: `gpio_detect_bank`

## Requirements
- R1: After a synchronous reset, output-enable is all ones, so no pin is driven. Data-out, both masks, all four event selects, the control register, the status register, the read data, the interrupt and the wake-up line are all zero.
- R2: The output-enable register sits at 0x34 and reads back its value. `pin_drive[n]` is 1 exactly when output-enable bit n is 0. It changes in the cycle after the write.
- R3: Data-out sits at 0x3C and drives `pin_out` directly. A write to 0x94 sets only the bits written as 1. A write to 0x90 clears only the bits written as 1.
- R4: Data-in at 0x38 returns the pin inputs after a two-flop synchroniser. A read issued in the cycle after a pin change still returns the old value. The second read after the change returns the new one.
- R5: The rising-edge select at 0x48 and the falling-edge select at 0x4C set status bit n on a 0-to-1 or a 1-to-0 change of synchronised pin n. Enabling both on one pin catches either edge.
- R6: The low-level select at 0x40 and the high-level select at 0x44 set status bit n in every cycle in which synchronised pin n holds that level.
- R7: Status at 0x18 is write-1-to-clear. Only the bits written as 1 are cleared, and writing all ones clears every edge event. A level event whose level persists stays set despite the clear.
- R8: The interrupt mask is written directly at 0x1C and read back there. A write to 0x64 sets only the bits written as 1, and a write to 0x60 clears only those bits. `irq` is the registered OR of status AND mask, so it follows one cycle after its inputs.
- R9: The wake-up mask is changed through 0x84 (set bits written as 1) and 0x80 (clear bits written as 1). `wake` is the registered OR of status AND wake-up mask.
- R10: The revision word at 0x00 returns the major number in bits 7:4 and the minor number in bits 3:0. All other bits read zero.
- R11: Control bit 0 at 0x30 suspends capture while it is 1. Status bits already set are kept. The control register reads back bit 0, and its other bits read zero.
- R12: Read data is registered. It appears in the cycle after `bus_rd` and holds until the next read. Unmapped addresses read zero. Writes to read-only or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and bank clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| pin_in | input | W | Asynchronous pin inputs |
| pin_out | output | W | Value driven onto pins |
| pin_drive | output | W | 1 where a pin is driven |
| irq | output | 1 | Bank interrupt |
| wake | output | 1 | Wake-up request |

## Verification
The assertions assume that the bus issues at most one strobe per cycle and that `bus_wr` and `bus_rd` are never high together. They also assume that the strobes stay low during reset, so that the first cycle after reset compares against known reset state. The stimulus drives every bus access as a single one-cycle pulse from a task. It changes pins only between accesses, with enough idle cycles that each pin change passes through the synchroniser before the next change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [7:0] OFF_REV     = 8'h00;
  localparam logic [7:0] OFF_STAT    = 8'h18;
  localparam logic [7:0] OFF_IEN     = 8'h1C;
  localparam logic [7:0] OFF_CTRL    = 8'h30;
  localparam logic [7:0] OFF_OE      = 8'h34;
  localparam logic [7:0] OFF_DIN     = 8'h38;
  localparam logic [7:0] OFF_DOUT    = 8'h3C;
  localparam logic [7:0] OFF_LO      = 8'h40;
  localparam logic [7:0] OFF_HI      = 8'h44;
  localparam logic [7:0] OFF_RISE    = 8'h48;
  localparam logic [7:0] OFF_FALL    = 8'h4C;
  localparam logic [7:0] OFF_IEN_CLR = 8'h60;
  localparam logic [7:0] OFF_IEN_SET = 8'h64;
  localparam logic [7:0] OFF_WEN_CLR = 8'h80;
  localparam logic [7:0] OFF_WEN_SET = 8'h84;
  localparam logic [7:0] OFF_DO_CLR  = 8'h90;
  localparam logic [7:0] OFF_DO_SET  = 8'h94;

  typedef struct packed {
    logic lo;
    logic hi;
    logic rise;
    logic fall;
  } sel_kind_t;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpb_detect.sv
module gpb_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic         arm,
  input  logic [W-1:0] lo_sel,
  input  logic [W-1:0] hi_sel,
  input  logic [W-1:0] rise_sel,
  input  logic [W-1:0] fall_sel,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= cur;
  end

  for (genvar n = 0; n < W; n++) begin : g_pin
    gpio_bank_pkg::sel_kind_t k;
    always_comb begin
      k.lo   = lo_sel[n]   & ~cur[n];
      k.hi   = hi_sel[n]   &  cur[n];
      k.rise = rise_sel[n] &  cur[n] & ~prev[n];
      k.fall = fall_sel[n] & ~cur[n] &  prev[n];
      hit[n] = arm & (|k);
    end
  end
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpio_bank_pkg::*;
#(
  parameter int W         = 32,
  parameter int ADDR_W    = 8,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      din,
  input  logic [W-1:0]      hit,
  output logic              freeze,
  output logic [W-1:0]      oe,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      status,
  output logic [W-1:0]      ien,
  output logic [W-1:0]      wen,
  output logic [W-1:0]      lo_sel,
  output logic [W-1:0]      hi_sel,
  output logic [W-1:0]      rise_sel,
  output logic [W-1:0]      fall_sel,
  output logic              irq,
  output logic              wake
);
  localparam logic [7:0] REV_BYTE = 8'(((REV_MAJOR % 16) * 16) + (REV_MINOR % 16));

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic [W-1:0] clr_mask;
  logic [W-1:0] rd_mux;

  assign clr_mask = (wr_en && at(addr, OFF_STAT)) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe       <= '1;
      dout     <= '0;
      status   <= '0;
      ien      <= '0;
      wen      <= '0;
      lo_sel   <= '0;
      hi_sel   <= '0;
      rise_sel <= '0;
      fall_sel <= '0;
      freeze   <= 1'b0;
      irq      <= 1'b0;
      wake     <= 1'b0;
    end else begin
      status <= (status & ~clr_mask) | hit;
      irq    <= |(status & ien);
      wake   <= |(status & wen);
      if (wr_en) begin
        if (at(addr, OFF_OE))      oe       <= wdata;
        if (at(addr, OFF_DOUT))    dout     <= wdata;
        if (at(addr, OFF_DO_SET))  dout     <= dout | wdata;
        if (at(addr, OFF_DO_CLR))  dout     <= dout & ~wdata;
        if (at(addr, OFF_IEN))     ien      <= wdata;
        if (at(addr, OFF_IEN_SET)) ien      <= ien | wdata;
        if (at(addr, OFF_IEN_CLR)) ien      <= ien & ~wdata;
        if (at(addr, OFF_WEN_SET)) wen      <= wen | wdata;
        if (at(addr, OFF_WEN_CLR)) wen      <= wen & ~wdata;
        if (at(addr, OFF_LO))      lo_sel   <= wdata;
        if (at(addr, OFF_HI))      hi_sel   <= wdata;
        if (at(addr, OFF_RISE))    rise_sel <= wdata;
        if (at(addr, OFF_FALL))    fall_sel <= wdata;
        if (at(addr, OFF_CTRL))    freeze   <= wdata[0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (at(addr, OFF_REV))  rd_mux = W'(REV_BYTE);
    if (at(addr, OFF_STAT)) rd_mux = status;
    if (at(addr, OFF_IEN))  rd_mux = ien;
    if (at(addr, OFF_CTRL)) rd_mux = W'(freeze);
    if (at(addr, OFF_OE))   rd_mux = oe;
    if (at(addr, OFF_DIN))  rd_mux = din;
    if (at(addr, OFF_DOUT)) rd_mux = dout;
    if (at(addr, OFF_LO))   rd_mux = lo_sel;
    if (at(addr, OFF_HI))   rd_mux = hi_sel;
    if (at(addr, OFF_RISE)) rd_mux = rise_sel;
    if (at(addr, OFF_FALL)) rd_mux = fall_sel;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_detect_bank.sv
module gpio_detect_bank #(
  parameter int W           = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REV_MAJOR   = 2,
  parameter int REV_MINOR   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_drive,
  output logic              irq,
  output logic              wake
);
  logic [W-1:0] pin_s;
  logic [W-1:0] hit_w;
  logic [W-1:0] oe_w;
  logic [W-1:0] stat_w;
  logic [W-1:0] ien_w;
  logic [W-1:0] wen_w;
  logic [W-1:0] lo_w, hi_w, rise_w, fall_w;
  logic         freeze_w;

  gpb_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  gpb_detect #(.W(W)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .cur      (pin_s),
    .arm      (~freeze_w),
    .lo_sel   (lo_w),
    .hi_sel   (hi_w),
    .rise_sel (rise_w),
    .fall_sel (fall_w),
    .hit      (hit_w)
  );

  gpb_regs #(
    .W(W), .ADDR_W(ADDR_W), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .din      (pin_s),
    .hit      (hit_w),
    .freeze   (freeze_w),
    .oe       (oe_w),
    .dout     (pin_out),
    .status   (stat_w),
    .ien      (ien_w),
    .wen      (wen_w),
    .lo_sel   (lo_w),
    .hi_sel   (hi_w),
    .rise_sel (rise_w),
    .fall_sel (fall_w),
    .irq      (irq),
    .wake     (wake)
  );

  assign pin_drive = ~oe_w;
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker
  import gpio_bank_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      rdata,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_drive,
  input logic              irq,
  input logic              wake,
  input logic [W-1:0]      status,
  input logic [W-1:0]      ien,
  input logic [W-1:0]      wen
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: one cycle after reset the outputs are idle
  always @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_idle: assert (!irq && !wake && pad_drive == '0 && pad_out == '0);
    end
  end

  // R7: a status bit falls only after a write to the status word
  a_r7_status_sticky: assert property (@(posedge clk) disable iff (rst)
    !($past(wr_en) && $past(addr) == ADDR_W'(OFF_STAT)) |-> (($past(status) & ~status) == '0));

  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
    ($past(ien) == '0) |-> !irq);

  a_r9_wake_needs_mask: assert property (@(posedge clk) disable iff (rst)
    ($past(wen) == '0) |-> !wake);

  a_r3_pad_out_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(pad_out));

  a_r2_drive_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(pad_drive));

  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata));
endmodule

bind gpio_detect_bank gpb_checker #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (bus_wr),
  .rd_en     (bus_rd),
  .addr      (bus_addr),
  .rdata     (bus_rdata),
  .pad_out   (pin_out),
  .pad_drive (pin_drive),
  .irq       (irq),
  .wake      (wake),
  .status    (stat_w),
  .ien       (ien_w),
  .wen       (wen_w)
);

// File: tb/tb_gpio_detect_bank.sv
`timescale 1ns/100ps
module tb_gpio_detect_bank;
  localparam int W  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0, pin_in = '0;
  logic [W-1:0]  bus_rdata, pin_out, pin_drive;
  logic          irq, wake;

  always #2.5 clk = ~clk;

  gpio_detect_bank #(.W(W), .ADDR_W(AW), .REV_MAJOR(2), .REV_MINOR(5)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_drive(pin_drive), .irq(irq), .wake(wake)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [W-1:0] m_s1, m_s2, m_prev, m_oe, m_do, m_st, m_ie, m_we;
  logic [W-1:0] m_lo, m_hi, m_ri, m_fa, m_rdata;
  logic         m_frz, m_irq, m_wake;
  logic [7:0]   m_raddr;

  function automatic logic [W-1:0] model_read(logic [7:0] a);
    case (a)
      8'h00: return 32'h25;
      8'h18: return m_st;
      8'h1C: return m_ie;
      8'h30: return {31'd0, m_frz};
      8'h34: return m_oe;
      8'h38: return m_s2;
      8'h3C: return m_do;
      8'h40: return m_lo;
      8'h44: return m_hi;
      8'h48: return m_ri;
      8'h4C: return m_fa;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R10";
      8'h18: return "R7";
      8'h1C: return "R8";
      8'h30: return "R11";
      8'h34: return "R2";
      8'h38: return "R4";
      8'h3C: return "R3";
      8'h40, 8'h44: return "R6";
      8'h48, 8'h4C: return "R5";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    logic [W-1:0] ev, clr;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_oe <= '1; m_do <= '0; m_st <= '0;
      m_ie <= '0; m_we <= '0; m_lo <= '0; m_hi <= '0; m_ri <= '0; m_fa <= '0;
      m_rdata <= '0; m_frz <= 1'b0; m_irq <= 1'b0; m_wake <= 1'b0; m_raddr <= 8'h04;
    end else begin
      ev = '0;
      for (int n = 0; n < W; n++) begin
        if (!m_frz) begin
          if (m_lo[n] && m_s2[n] == 1'b0) ev[n] = 1'b1;
          if (m_hi[n] && m_s2[n] == 1'b1) ev[n] = 1'b1;
          if (m_ri[n] && m_s2[n] && !m_prev[n]) ev[n] = 1'b1;
          if (m_fa[n] && !m_s2[n] && m_prev[n]) ev[n] = 1'b1;
        end
      end
      clr = (bus_wr && bus_addr == 8'h18) ? bus_wdata : '0;
      m_st   <= (m_st & ~clr) | ev;
      m_irq  <= (m_st & m_ie) != 0;
      m_wake <= (m_st & m_we) != 0;
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      if (bus_rd) begin
        m_rdata <= model_read(bus_addr);
        m_raddr <= bus_addr;
      end
      if (bus_wr) begin
        case (bus_addr)
          8'h1C: m_ie <= bus_wdata;
          8'h30: m_frz <= bus_wdata[0];
          8'h34: m_oe <= bus_wdata;
          8'h3C: m_do <= bus_wdata;
          8'h40: m_lo <= bus_wdata;
          8'h44: m_hi <= bus_wdata;
          8'h48: m_ri <= bus_wdata;
          8'h4C: m_fa <= bus_wdata;
          8'h60: m_ie <= m_ie & ~bus_wdata;
          8'h64: m_ie <= m_ie | bus_wdata;
          8'h80: m_we <= m_we & ~bus_wdata;
          8'h84: m_we <= m_we | bus_wdata;
          8'h90: m_do <= m_do & ~bus_wdata;
          8'h94: m_do <= m_do | bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R3", "pin_out", pin_out, m_do);
      check("R2", "pin_drive", pin_drive, ~m_oe);
      check("R8", "irq", {31'd0, irq}, {31'd0, m_irq});
      check("R9", "wake", {31'd0, wake}, {31'd0, m_wake});
      check(tag_of(m_raddr), "rdata", bus_rdata, m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [7:0] a, logic [W-1:0] d);
    @(negedge clk); #1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic rd_expect(logic [7:0] a, logic [W-1:0] exp, string tag);
    @(negedge clk); #1; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); #1; bus_rd = 1'b0;
    check(tag, "read", bus_rdata, exp);
  endtask

  task automatic pins(logic [W-1:0] v);
    @(negedge clk); #1; pin_in = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(4); #1; rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "irq", {31'd0, irq}, 32'd0);
    check("R1", "wake", {31'd0, wake}, 32'd0);
    check("R1", "pin_drive", pin_drive, 32'd0);
    check("R1", "pin_out", pin_out, 32'd0);
    rd_expect(8'h34, 32'hFFFF_FFFF, "R1");
    rd_expect(8'h18, 32'h0, "R1");

    // R10 revision, R12 unmapped and read-only
    rd_expect(8'h00, 32'h0000_0025, "R10");
    rd_expect(8'h04, 32'h0, "R12");
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_expect(8'h38, 32'h0, "R12");
    rd_expect(8'h00, 32'h0000_0025, "R12");
    idle(3);

    // R2 direction, R3 data-out aliases
    wr(8'h34, 32'hFFFF_0000);
    check("R2", "pin_drive after write", pin_drive, 32'h0000_FFFF);
    wr(8'h3C, 32'h0000_00F0);
    wr(8'h94, 32'h0000_000F);
    wr(8'h90, 32'h0000_0030);
    check("R3", "pin_out after aliases", pin_out, 32'h0000_00CF);
    rd_expect(8'h3C, 32'h0000_00CF, "R3");
    rd_expect(8'h34, 32'hFFFF_0000, "R2");

    // R4 synchroniser delay
    pins(32'hA5A5_0001);
    rd_expect(8'h38, 32'h0, "R4");
    rd_expect(8'h38, 32'hA5A5_0001, "R4");
    pins(32'h0);
    idle(4);

    // R5 edges: rise on 0, fall on 1, both on 2
    wr(8'h48, 32'h5);
    wr(8'h4C, 32'h6);
    wr(8'h18, 32'hFFFF_FFFF);
    pins(32'h7);
    idle(4);
    rd_expect(8'h18, 32'h5, "R5");
    wr(8'h18, 32'hFFFF_FFFF);
    pins(32'h0);
    idle(4);
    rd_expect(8'h18, 32'h6, "R5");
    wr(8'h18, 32'h4);
    rd_expect(8'h18, 32'h2, "R7");
    wr(8'h18, 32'hFFFF_FFFF);
    rd_expect(8'h18, 32'h0, "R7");

    // R6 levels, R7 persistence
    wr(8'h44, 32'h10);
    wr(8'h40, 32'h20);
    pins(32'h10);
    idle(4);
    rd_expect(8'h18, 32'h30, "R6");
    wr(8'h18, 32'h30);
    rd_expect(8'h18, 32'h30, "R7");
    pins(32'h20);
    idle(4);
    wr(8'h18, 32'h30);
    rd_expect(8'h18, 32'h0, "R7");
    wr(8'h40, 32'h0);
    wr(8'h44, 32'h0);

    // R8 interrupt mask and aliases
    pins(32'h21);
    idle(4);
    wr(8'h1C, 32'h1);
    idle(1);
    check("R8", "irq raised", {31'd0, irq}, 32'd1);
    wr(8'h60, 32'h1);
    idle(1);
    check("R8", "irq dropped", {31'd0, irq}, 32'd0);
    wr(8'h64, 32'h1);
    idle(1);
    check("R8", "irq back", {31'd0, irq}, 32'd1);
    rd_expect(8'h1C, 32'h1, "R8");

    // R9 wake mask
    wr(8'h84, 32'h1);
    idle(1);
    check("R9", "wake raised", {31'd0, wake}, 32'd1);
    wr(8'h80, 32'h1);
    idle(1);
    check("R9", "wake dropped", {31'd0, wake}, 32'd0);

    // R11 capture suspend
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    rd_expect(8'h30, 32'h1, "R11");
    pins(32'h20);
    idle(4);
    pins(32'h21);
    idle(4);
    rd_expect(8'h18, 32'h0, "R11");
    wr(8'h30, 32'h0);
    pins(32'h20);
    idle(4);
    pins(32'h21);
    idle(4);
    rd_expect(8'h18, 32'h1, "R11");
    idle(5);
    finish_run();
  end
endmodule